// File: doc/BRIEF.md
# Programmable Video Reference Delay Unit

This block decides when interpolated picture data begins on every output frame. It watches a vertical reference and a horizontal reference and measures two programmable offsets from them. The first is a number of lines counted from the vertical reference. The second is a number of pixel-enable periods counted from each horizontal reference. Each measured offset is the programmed value plus a fixed pipeline latency, and that latency depends on where the references come from. The block raises a line-valid strobe once the line offset has elapsed. It raises a pixel-valid strobe within such lines once the pixel offset has elapsed.

The references come from one of two places, chosen by a control bit. With the bit clear, they come from two input pins. With the bit set, a built-in 625-line or 525-line sync generator produces them. In that case the block also drives active-low horizontal, vertical and composite sync outputs, and raises an output-enable so that the shared reference pins at the board level can turn into sync drivers. Configuration arrives through a plain single-cycle write port. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure. The strobes are level outputs that the downstream datapath samples on every pixel enable.

Top module: `vrd_top`

## Requirements
- R1: After reset, `line_valid` and `pix_valid` are low, all three sync outputs are high, `sync_oe` is low, and every configuration field is zero (external references, 625-line standard, zero delays).
- R2: A write with `cfg_we` high takes effect in the next cycle. Address 0 sets the source bit (bit 0: 1 = internal generator) and the standard bit (bit 1: 1 = 525-line). Address 1 sets the line delay from bits 5:0. Address 2 sets the pixel delay from bits 9:0. A write to address 3 changes nothing.
- R3: A reference edge is a low-to-high change of the selected reference level, and it is seen only in a cycle with `pix_en` high. The previous level is sampled only on `pix_en`. A level held high over many pixel periods gives exactly one edge. The stored previous levels reset to high.
- R4: After a vertical edge, `line_valid` is low. It goes high once the number of horizontal edges since that vertical edge exceeds the line delay plus the line latency (1 with external references, 2 with internal). A horizontal edge in the same cycle as the vertical edge is not counted.
- R5: `pix_valid` is high when `line_valid` is high, a horizontal edge has been seen since reset, and the number of `pix_en` cycles since the last horizontal edge is at least the pixel delay plus the pixel latency (3 with external references, 5 with internal).
- R6: The line counter saturates at 127 and the pixel counter saturates at 2047. Neither wraps, so the strobes stay high for as long as the references stay quiet.
- R7: The internal generator advances its pixel counter on `pix_en`. A line is 864 pixels in the 625-line standard and 858 pixels in the 525-line standard, and a frame is 625 or 525 lines. `hsync_n` is low for the first `HSYNC_W` pixels of each line and `vsync_n` is low for the first `VSYNC_L` lines of each frame. The generator is free-running from reset.
- R8: With the internal source, `csync_n` is the XNOR of `hsync_n` and `vsync_n`, and `sync_oe` is high. With the external source, all sync outputs are held high and `sync_oe` is low.
- R9: With the internal source, `ext_href` and `ext_vref` have no effect on any output.
- R10: Until the first vertical edge after reset, `line_valid` and `pix_valid` remain low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 10 | Configuration write data |
| ext_vref | input | 1 | External vertical reference, active high |
| ext_href | input | 1 | External horizontal reference, active high |
| line_valid | output | 1 | Line delay has elapsed in this frame |
| pix_valid | output | 1 | Pixel delay has elapsed in the current valid line |
| sync_oe | output | 1 | Internal source selected; sync outputs are driven |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| csync_n | output | 1 | Composite sync, active low |

## Verification
The hardest state to reach from the ports is saturation of both counters. Saturating the line counter takes more than a hundred horizontal edges without a vertical edge. Saturating the pixel counter takes more than two thousand pixel enables without a horizontal edge. The bench reaches both by reprogramming its external reference generator to a very long frame, and then to a very long line, with the largest delays written in. A behavioural model follows every cycle, so the same phases also cover irregular `pix_en`, wide reference pulses, an ignored address, and switching between the two standards.

// File: rtl/vrd_pkg.sv
package vrd_pkg;
  localparam int LDLY_W = 6;
  localparam int PDLY_W = 10;
  localparam int ADDR_W = 2;
  localparam int WDAT_W = PDLY_W;
  localparam int LCNT_W = LDLY_W + 1;
  localparam int PCNT_W = PDLY_W + 1;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_LINE = 2'd1,
    SEL_PIX  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic              use_int;
    logic              std525;
    logic [LDLY_W-1:0] ldly;
    logic [PDLY_W-1:0] pdly;
  } vrd_cfg_t;
endpackage

// File: rtl/vrd_regs.sv
module vrd_regs
  import vrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WDAT_W-1:0] wdata,
  output vrd_cfg_t          cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      case (reg_sel_e'(addr))
        SEL_CTRL: begin
          cfg.use_int <= wdata[0];
          cfg.std525  <= wdata[1];
        end
        SEL_LINE: cfg.ldly <= wdata[LDLY_W-1:0];
        SEL_PIX:  cfg.pdly <= wdata[PDLY_W-1:0];
        default:  ;
      endcase
    end
  end

  // R2: an unused address leaves the configuration alone
  assert_unused_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == SEL_NONE) |=> $stable(cfg));
endmodule

// File: rtl/vrd_syncgen.sv
module vrd_syncgen #(
  parameter int H_TOT_A = 864,
  parameter int V_TOT_A = 625,
  parameter int H_TOT_B = 858,
  parameter int V_TOT_B = 525,
  parameter int HSYNC_W = 64,
  parameter int VSYNC_L = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_en,
  input  logic std_b,
  output logic hs_n,
  output logic vs_n
);
  localparam int HMAX = (H_TOT_A > H_TOT_B) ? H_TOT_A : H_TOT_B;
  localparam int VMAX = (V_TOT_A > V_TOT_B) ? V_TOT_A : V_TOT_B;
  localparam int HCW  = $clog2(HMAX);
  localparam int VCW  = $clog2(VMAX);
  localparam logic [HCW-1:0] HLAST_A = HCW'(H_TOT_A - 1);
  localparam logic [HCW-1:0] HLAST_B = HCW'(H_TOT_B - 1);
  localparam logic [VCW-1:0] VLAST_A = VCW'(V_TOT_A - 1);
  localparam logic [VCW-1:0] VLAST_B = VCW'(V_TOT_B - 1);
  localparam logic [HCW-1:0] HS_END  = HCW'(HSYNC_W);
  localparam logic [VCW-1:0] VS_END  = VCW'(VSYNC_L);

  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;
  logic [HCW-1:0] hlast;
  logic [VCW-1:0] vlast;

  assign hlast = std_b ? HLAST_B : HLAST_A;
  assign vlast = std_b ? VLAST_B : VLAST_A;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (pix_en) begin
      if (hcnt >= hlast) begin
        hcnt <= '0;
        vcnt <= (vcnt >= vlast) ? '0 : vcnt + 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  assign hs_n = !(hcnt < HS_END);
  assign vs_n = !(vcnt < VS_END);

  // R7: counters stay inside the longest line and frame
  assert_hcnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt < HCW'(HMAX));
  assert_vcnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt < VCW'(VMAX));
  // R7: the generator only moves on pixel enables
  assert_hold_no_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(hcnt) && $stable(vcnt));
endmodule

// File: rtl/vrd_edge.sv
module vrd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_en,
  input  logic lvl,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev <= 1'b1;
    else if (pix_en) prev <= lvl;
  end

  assign rise = pix_en && lvl && !prev;

  // R3: edges appear only with a pixel enable and never twice in a row
  assert_edge_qual_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> pix_en);
  assert_edge_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/vrd_counter.sv
module vrd_counter
  import vrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              v_edge,
  input  logic              h_edge,
  input  logic [LCNT_W-1:0] line_thr,
  input  logic [PCNT_W-1:0] pix_thr,
  output logic              line_valid,
  output logic              pix_valid
);
  localparam logic [LCNT_W-1:0] LSAT = '1;
  localparam logic [PCNT_W-1:0] PSAT = '1;

  logic [LCNT_W-1:0] lcnt;
  logic [PCNT_W-1:0] pcnt;
  logic              frame_seen;
  logic              line_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcnt       <= '0;
      frame_seen <= 1'b0;
    end else if (v_edge) begin
      lcnt       <= '0;
      frame_seen <= 1'b1;
    end else if (h_edge && lcnt != LSAT) begin
      lcnt <= lcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt      <= '0;
      line_seen <= 1'b0;
    end else if (h_edge) begin
      pcnt      <= '0;
      line_seen <= 1'b1;
    end else if (pix_en && pcnt != PSAT) begin
      pcnt <= pcnt + 1'b1;
    end
  end

  assign line_valid = frame_seen && (lcnt > line_thr);
  assign pix_valid  = line_valid && line_seen && (pcnt >= pix_thr);

  // R4: a new frame always starts with the line strobe low
  assert_frame_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    v_edge |=> !line_valid);
  // R6: saturated counters hold their value
  assert_lsat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lcnt == LSAT && !v_edge) |=> lcnt == LSAT);
  assert_psat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt == PSAT && !h_edge) |=> pcnt == PSAT);
endmodule

// File: rtl/vrd_top.sv
module vrd_top
  import vrd_pkg::*;
#(
  parameter int H_TOT_625    = 864,
  parameter int V_TOT_625    = 625,
  parameter int H_TOT_525    = 858,
  parameter int V_TOT_525    = 525,
  parameter int HSYNC_W      = 64,
  parameter int VSYNC_L      = 3,
  parameter int LAT_LINE_EXT = 1,
  parameter int LAT_LINE_INT = 2,
  parameter int LAT_PIX_EXT  = 3,
  parameter int LAT_PIX_INT  = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_en,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [9:0]  cfg_wdata,
  input  logic        ext_vref,
  input  logic        ext_href,
  output logic        line_valid,
  output logic        pix_valid,
  output logic        sync_oe,
  output logic        hsync_n,
  output logic        vsync_n,
  output logic        csync_n
);
  localparam int NREF = 2;
  localparam logic [LCNT_W-1:0] LLAT [2] = '{LCNT_W'(LAT_LINE_EXT), LCNT_W'(LAT_LINE_INT)};
  localparam logic [PCNT_W-1:0] PLAT [2] = '{PCNT_W'(LAT_PIX_EXT), PCNT_W'(LAT_PIX_INT)};

  vrd_cfg_t          cfg;
  logic              hs_n_int;
  logic              vs_n_int;
  logic [NREF-1:0]   ref_lvl;
  logic [NREF-1:0]   ref_rise;
  logic [LCNT_W-1:0] line_thr;
  logic [PCNT_W-1:0] pix_thr;

  vrd_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  vrd_syncgen #(
    .H_TOT_A (H_TOT_625),
    .V_TOT_A (V_TOT_625),
    .H_TOT_B (H_TOT_525),
    .V_TOT_B (V_TOT_525),
    .HSYNC_W (HSYNC_W),
    .VSYNC_L (VSYNC_L)
  ) u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .pix_en (pix_en),
    .std_b  (cfg.std525),
    .hs_n   (hs_n_int),
    .vs_n   (vs_n_int)
  );

  // index 0: vertical reference, index 1: horizontal reference
  assign ref_lvl[0] = cfg.use_int ? !vs_n_int : ext_vref;
  assign ref_lvl[1] = cfg.use_int ? !hs_n_int : ext_href;

  for (genvar g = 0; g < NREF; g++) begin : g_ref
    vrd_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pix_en (pix_en),
      .lvl    (ref_lvl[g]),
      .rise   (ref_rise[g])
    );
  end

  assign line_thr = {1'b0, cfg.ldly} + LLAT[cfg.use_int];
  assign pix_thr  = {1'b0, cfg.pdly} + PLAT[cfg.use_int];

  vrd_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_en     (pix_en),
    .v_edge     (ref_rise[0]),
    .h_edge     (ref_rise[1]),
    .line_thr   (line_thr),
    .pix_thr    (pix_thr),
    .line_valid (line_valid),
    .pix_valid  (pix_valid)
  );

  assign sync_oe = cfg.use_int;
  assign hsync_n = cfg.use_int ? hs_n_int : 1'b1;
  assign vsync_n = cfg.use_int ? vs_n_int : 1'b1;
  assign csync_n = cfg.use_int ? !(hs_n_int ^ vs_n_int) : 1'b1;

  // R5: pixel strobe never appears outside a valid line
  assert_pix_in_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> line_valid);
  // R8: with the outputs disabled no sync pulse escapes
  assert_quiet_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_oe |-> (hsync_n && vsync_n && csync_n));
endmodule

// File: tb/sim_vrd_top.sv
`timescale 1ns/1ps
module sim_vrd_top;
  localparam int HA = 20, VA = 7, HB = 16, VB = 6, HSW = 3, VSL = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_en = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [9:0] cfg_wdata = '0;
  logic       ext_vref = 1'b0;
  logic       ext_href = 1'b0;
  logic       line_valid, pix_valid, sync_oe, hsync_n, vsync_n, csync_n;

  always #2.5 clk = ~clk;

  vrd_top #(.H_TOT_625(HA), .V_TOT_625(VA), .H_TOT_525(HB), .V_TOT_525(VB),
            .HSYNC_W(HSW), .VSYNC_L(VSL)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ext_vref(ext_vref),
    .ext_href(ext_href), .line_valid(line_valid), .pix_valid(pix_valid),
    .sync_oe(sync_oe), .hsync_n(hsync_n), .vsync_n(vsync_n), .csync_n(csync_n));

  int checks = 0, failures = 0;
  bit cmp_on = 1'b0;

  // behavioural reference state
  int m_int, m_std, m_ld, m_pd, m_hc, m_vc, m_ph, m_pv, m_lc, m_pc, m_fs, m_hs;

  always @(posedge clk) begin
    int rv, rh, ve, he, ht, vt;
    if (!rst_n) begin
      m_int = 0; m_std = 0; m_ld = 0; m_pd = 0; m_hc = 0; m_vc = 0;
      m_ph = 1; m_pv = 1; m_lc = 0; m_pc = 0; m_fs = 0; m_hs = 0;
    end else begin
      rv = m_int ? int'(m_vc < VSL) : int'(ext_vref);
      rh = m_int ? int'(m_hc < HSW) : int'(ext_href);
      ve = int'(pix_en && rv != 0 && m_pv == 0);
      he = int'(pix_en && rh != 0 && m_ph == 0);
      if (ve != 0) begin m_fs = 1; m_lc = 0; end
      else if (he != 0 && m_lc != 127) m_lc++;
      if (he != 0) begin m_hs = 1; m_pc = 0; end
      else if (pix_en && m_pc != 2047) m_pc++;
      if (pix_en) begin m_ph = rh; m_pv = rv; end
      ht = m_std ? HB : HA;
      vt = m_std ? VB : VA;
      if (pix_en) begin
        if (m_hc >= ht - 1) begin
          m_hc = 0;
          m_vc = (m_vc >= vt - 1) ? 0 : m_vc + 1;
        end else m_hc++;
      end
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: begin m_int = int'(cfg_wdata[0]); m_std = int'(cfg_wdata[1]); end
          2'd1: m_ld = int'(cfg_wdata[5:0]);
          2'd2: m_pd = int'(cfg_wdata[9:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic e_lv, e_pv, e_hs, e_vs;
    if (cmp_on) begin
      e_lv = (m_fs != 0) && (m_lc > m_ld + (m_int ? 2 : 1));           // R4 R10
      e_pv = e_lv && (m_hs != 0) && (m_pc >= m_pd + (m_int ? 5 : 3));  // R5 R6
      e_hs = m_int ? !(m_hc < HSW) : 1'b1;                              // R7
      e_vs = m_int ? !(m_vc < VSL) : 1'b1;
      chk("R4 line_valid", line_valid, e_lv);
      chk("R5 pix_valid", pix_valid, e_pv);
      chk("R7 hsync_n", hsync_n, e_hs);
      chk("R7 vsync_n", vsync_n, e_vs);
      chk("R8 csync_n", csync_n, m_int ? (e_hs == e_vs) : 1'b1);
      chk("R8 sync_oe", sync_oe, m_int != 0);
    end
  end

  // external reference pattern generator
  int eh = 24, ehw = 2, ev = 8, epx = 0, eln = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic run(input int n, input int pe_mode, input bit noise);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (pe_mode)
        0: pix_en = 1'b1;
        1: pix_en = ~pix_en;
        default: pix_en = lf[0] | lf[3];
      endcase
      if (noise) begin
        ext_href = lf[5];   // R9: ignored in internal mode
        ext_vref = lf[7];
      end else begin
        ext_href = (epx < ehw);
        ext_vref = (eln == 0);
        if (pix_en) begin
          if (epx >= eh - 1) begin
            epx = 0;
            eln = (eln >= ev - 1) ? 0 : eln + 1;
          end else epx++;
        end
      end
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  bit done = 1'b0;
  initial begin
    #(5ns * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 line_valid", line_valid, 1'b0);
    chk("R1 pix_valid", pix_valid, 1'b0);
    chk("R1 sync_oe", sync_oe, 1'b0);
    chk("R1 hsync_n", hsync_n, 1'b1);
    chk("R1 csync_n", csync_n, 1'b1);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    // R10 and R4/R5 with zero delays, continuous enable
    run(600, 0, 1'b0);
    // R2: programmed delays, every other cycle enabled
    wr(2'd1, 10'd2);
    wr(2'd2, 10'd4);
    run(1200, 1, 1'b0);
    // R3: wide reference pulses under irregular enable
    ehw = 9; eh = 30; ev = 6;
    run(2000, 2, 1'b0);
    // R2: address 3 must change nothing
    wr(2'd3, 10'h3FF);
    run(500, 2, 1'b0);
    // R7 R8 R9: internal generator, 625-line totals, noisy pins
    wr(2'd0, 10'd1);
    wr(2'd1, 10'd1);
    wr(2'd2, 10'd6);
    run(1500, 0, 1'b1);
    run(1000, 2, 1'b1);
    // R7: 525-line totals
    wr(2'd0, 10'd3);
    run(1500, 1, 1'b1);
    // R6: line counter saturation with a very long frame
    wr(2'd0, 10'd0);
    wr(2'd1, 10'd63);
    wr(2'd2, 10'd1);
    eh = 4; ehw = 1; ev = 2000; epx = 0; eln = 0;
    run(900, 0, 1'b0);
    // R6: pixel counter saturation with a very long line
    wr(2'd2, 10'd1023);
    eh = 3000;
    run(2600, 0, 1'b0);
    cmp_on = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule